// File: doc/BRIEF.md
# Loop Instruction Cache with Shared Program-Port Arbitration

This block sits between an instruction sequencer and a single program-memory read port. The same port also serves coefficient reads from a data path. A small fully associative store keeps the instructions most recently brought in from memory. When a fetch finds its instruction in the store, the port is free in that cycle, so a coefficient read proceeds in parallel. The instruction and the coefficient then both complete in one cycle.

On a miss, the instruction fetch takes the port and any coefficient read that arrives in the same cycle waits. The first pass through a tight loop therefore costs two cycles per instruction when each instruction also needs a coefficient. Every later pass costs one cycle. Both requesters use a request/ready handshake and must hold a request until it is accepted. Every accepted request answers exactly one cycle later with a valid pulse. The memory port answers one cycle after it is driven.

Top module: `loop_icache`

## Requirements
- R1: After reset the store is empty and the fill pointer is at slot 0. `fetch_valid`, `coef_valid` and `pm_req` are low until a request is accepted.
- R2: A fetch whose address is held in the store is accepted at once and does not use the port. The instruction appears on `fetch_instr` with `fetch_valid` high in the next cycle.
- R3: In a cycle where the fetch hits, or where there is no fetch, a coefficient request is granted the port (`coef_ready` high). Its data appears on `coef_data` with `coef_valid` high in the next cycle.
- R4: A fetch that misses drives `pm_req` with `pm_addr` equal to the fetch address. In the next cycle the word on `pm_rdata` is presented on `fetch_instr` and is also written into the store.
- R5: When a missing fetch and a coefficient request collide, the fetch takes the port and `coef_ready` is low in that cycle.
- R6: A coefficient request that was stalled in the previous cycle and is still held takes the port first. A fetch that misses in that cycle sees `fetch_ready` low. A fetch that hits in that cycle is still accepted. No coefficient read ever stalls for two cycles in a row.
- R7: The store has 32 entries, each with a valid bit and a full address tag. Fills go to slots 0, 1, …, 31 in turn and then wrap. The 33rd distinct fill after a flush evicts the first address filled, and only that address.
- R8: A one-cycle `flush` pulse invalidates all entries and returns the fill pointer to slot 0. A fill returning in that same cycle is dropped, so its address misses afterwards.
- R9: A fetch to the address whose fill is in flight counts as a hit. It makes no second port read and returns the same word one cycle later.
- R10: The port carries at most one request per cycle, and read data is taken from `pm_rdata` exactly one cycle after `pm_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every store entry |
| fetch_req | input | 1 | Sequencer requests an instruction |
| fetch_addr | input | 16 | Instruction address |
| fetch_ready | output | 1 | Fetch accepted this cycle |
| fetch_valid | output | 1 | Instruction response valid |
| fetch_instr | output | 32 | Instruction word |
| coef_req | input | 1 | Coefficient read request |
| coef_addr | input | 16 | Coefficient address |
| coef_ready | output | 1 | Coefficient read accepted this cycle |
| coef_valid | output | 1 | Coefficient response valid |
| coef_data | output | 32 | Coefficient word |
| pm_req | output | 1 | Program-memory read strobe |
| pm_addr | output | 16 | Program-memory address |
| pm_rdata | input | 32 | Program-memory data, one cycle after the strobe |

## Verification
The hardest state to reach from the ports has three conditions at once. A coefficient stalled by a collision is still held, a new fetch misses, and at the same time an older fill is landing or a flush arrives. A directed sequence drives a miss together with a coefficient and then a second, different miss on the next cycle, so the priority reversal of R6 is observed in isolation. A long pipelined run follows. In it, loop addresses span more than the store's capacity, coefficient requests are random and held until accepted, and occasional flushes hit the store, so the stall, eviction, forwarding and flush cases interleave. A behavioural model compares the outputs on every clock.

// File: rtl/lic_pkg.sv
package lic_pkg;

    // One grant per port cycle: at most one of these is set.
    typedef struct packed {
        logic fetch;
        logic coef;
    } pm_grant_t;

    // Where the next fetch response is taken from.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HELD = 2'd1,
        SRC_PORT = 2'd2
    } fetch_src_t;

    localparam int unsigned LIC_LINES  = 32;
    localparam int unsigned LIC_ADDR_W = 16;
    localparam int unsigned LIC_DATA_W = 32;

    // Round-robin successor of a slot index.
    function automatic int unsigned next_slot(input int unsigned cur, input int unsigned lines);
        return (cur == lines - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/lic_tag_cam.sv
module lic_tag_cam #(
    parameter int unsigned LINES  = 32,
    parameter int unsigned ADDR_W = 16,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic [IDX_W-1:0]  fill_idx
);
    import lic_pkg::*;

    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  match;
    logic [ADDR_W-1:0] tag_q [LINES];
    logic [IDX_W-1:0]  ptr_q;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (tag_q[g] == look_addr);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign fill_idx = ptr_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (fill_en) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q          <= IDX_W'(next_slot(int'(ptr_q), LINES));
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) tag_q[ptr_q] <= fill_addr;
    end

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    // R7
    fill_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush) |=> (valid_q[$past(ptr_q)] && tag_q[$past(ptr_q)] == $past(fill_addr)));

    // R9
    no_dup_tag_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

endmodule

// File: rtl/lic_data_ram.sv
module lic_data_ram #(
    parameter int unsigned LINES  = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [LINES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/lic_port_arb.sv
module lic_port_arb (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_req,
    input  logic               fetch_hit,
    input  logic               coef_req,
    output lic_pkg::pm_grant_t grant,
    output logic               fetch_ready,
    output logic               coef_ready
);
    import lic_pkg::*;

    logic wait_q;
    logic coef_first;

    assign coef_first = wait_q && coef_req;

    always_comb begin
        grant = '0;
        if (coef_first) begin
            grant.coef = 1'b1;
        end else if (fetch_req && !fetch_hit) begin
            grant.fetch = 1'b1;
        end else begin
            grant.coef = coef_req;
        end
    end

    assign fetch_ready = !(coef_first && !fetch_hit);
    assign coef_ready  = !grant.fetch;

    always_ff @(posedge clk) begin
        if (rst) wait_q <= 1'b0;
        else     wait_q <= coef_req && !coef_ready;
    end

    // R10
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R6
    coef_stall_once_chk: assert property (@(posedge clk) disable iff (rst)
        (coef_req && !coef_ready) |=> (!coef_req || coef_ready));

endmodule

// File: rtl/loop_icache.sv
module loop_icache #(
    parameter int unsigned LINES  = lic_pkg::LIC_LINES,
    parameter int unsigned ADDR_W = lic_pkg::LIC_ADDR_W,
    parameter int unsigned DATA_W = lic_pkg::LIC_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_instr,
    input  logic              coef_req,
    input  logic [ADDR_W-1:0] coef_addr,
    output logic              coef_ready,
    output logic              coef_valid,
    output logic [DATA_W-1:0] coef_data,
    output logic              pm_req,
    output logic [ADDR_W-1:0] pm_addr,
    input  logic [DATA_W-1:0] pm_rdata
);
    import lic_pkg::*;

    localparam int unsigned IDX_W = $clog2(LINES);

    pm_grant_t         grant;
    fetch_src_t        src_q;
    logic              fill_pend_q;
    logic [ADDR_W-1:0] fill_addr_q;
    logic              cam_hit;
    logic              fwd_hit;
    logic              any_hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  fill_idx;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] held_q;
    logic              coef_valid_q;
    logic              fetch_take;

    // A fill in flight is visible to a lookup one cycle before it lands.
    assign fwd_hit = fill_pend_q && (fill_addr_q == fetch_addr);
    assign any_hit = cam_hit || fwd_hit;

    lic_tag_cam #(.LINES(LINES), .ADDR_W(ADDR_W)) i_cam (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .look_addr (fetch_addr),
        .hit       (cam_hit),
        .hit_idx   (hit_idx),
        .fill_en   (fill_pend_q),
        .fill_addr (fill_addr_q),
        .fill_idx  (fill_idx)
    );

    lic_data_ram #(.LINES(LINES), .DATA_W(DATA_W)) i_ram (
        .clk   (clk),
        .we    (fill_pend_q && !flush),
        .waddr (fill_idx),
        .wdata (pm_rdata),
        .raddr (hit_idx),
        .rdata (ram_rdata)
    );

    lic_port_arb i_arb (
        .clk         (clk),
        .rst         (rst),
        .fetch_req   (fetch_req),
        .fetch_hit   (any_hit),
        .coef_req    (coef_req),
        .grant       (grant),
        .fetch_ready (fetch_ready),
        .coef_ready  (coef_ready)
    );

    assign fetch_take = fetch_req && fetch_ready;
    assign pm_req     = grant.fetch || grant.coef;
    assign pm_addr    = grant.fetch ? fetch_addr : coef_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q        <= SRC_NONE;
            fill_pend_q  <= 1'b0;
            coef_valid_q <= 1'b0;
        end else begin
            fill_pend_q  <= grant.fetch;
            coef_valid_q <= grant.coef;
            if (!fetch_take)      src_q <= SRC_NONE;
            else if (grant.fetch) src_q <= SRC_PORT;
            else                  src_q <= SRC_HELD;
        end
    end

    always_ff @(posedge clk) begin
        if (grant.fetch) fill_addr_q <= fetch_addr;
        if (fetch_take)  held_q      <= fwd_hit ? pm_rdata : ram_rdata;
    end

    assign fetch_valid = (src_q != SRC_NONE);
    assign fetch_instr = (src_q == SRC_PORT) ? pm_rdata : held_q;
    assign coef_valid  = coef_valid_q;
    assign coef_data   = pm_rdata;

    // R4
    miss_returns_chk: assert property (@(posedge clk) disable iff (rst)
        grant.fetch |=> (fetch_valid && fetch_instr == pm_rdata));

    // R2
    hit_no_port_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && any_hit) |-> !grant.fetch);

    // R3
    coef_resp_chk: assert property (@(posedge clk) disable iff (rst)
        coef_valid |-> $past(coef_req && coef_ready));

    // R2
    fetch_resp_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> $past(fetch_req && fetch_ready));

endmodule

// File: tb/test_loop_icache.sv
module test_loop_icache;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        fetch_ready, fetch_valid;
    logic [31:0] fetch_instr;
    logic        coef_req = 1'b0;
    logic [15:0] coef_addr = '0;
    logic        coef_ready, coef_valid;
    logic [31:0] coef_data;
    logic        pm_req;
    logic [15:0] pm_addr;
    logic [31:0] pm_rdata;

    always #(CLK_P/2) clk = ~clk;

    loop_icache i_loop_icache (
        .clk(clk), .rst(rst), .flush(flush),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .fetch_valid(fetch_valid), .fetch_instr(fetch_instr),
        .coef_req(coef_req), .coef_addr(coef_addr), .coef_ready(coef_ready),
        .coef_valid(coef_valid), .coef_data(coef_data),
        .pm_req(pm_req), .pm_addr(pm_addr), .pm_rdata(pm_rdata)
    );

    function automatic logic [31:0] memf(input logic [15:0] a);
        return {a, ~a} ^ 32'h3C5A_96E1;
    endfunction

    // Memory: one-cycle read latency (R10)
    always @(posedge clk) pm_rdata <= memf(pm_addr);

    int n_chk = 0;
    int n_err = 0;
    int ireads = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          mv [32];
    logic [15:0] mt [32];
    int          mptr;
    bit          mwait, mpend;
    logic [15:0] mpaddr;
    bit          e_fv, e_cv;
    logic [31:0] e_fi, e_cd;
    bit          m_hit, m_gf, m_gc, m_first, m_efr, m_ecr;

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) mv[i] = 0;
            mptr = 0; mwait = 0; mpend = 0; e_fv = 0; e_cv = 0;
        end else begin
            m_hit = 0;
            for (int i = 0; i < 32; i++) if (mv[i] && mt[i] == fetch_addr) m_hit = 1;
            if (mpend && mpaddr == fetch_addr) m_hit = 1;   // R9
            m_first = mwait && coef_req;
            m_gf = 0; m_gc = 0;
            if (m_first) m_gc = 1;
            else if (fetch_req && !m_hit) m_gf = 1;
            else m_gc = coef_req;
            m_efr = !(m_first && !m_hit);
            m_ecr = !m_gf;

            chk(fetch_ready == m_efr, "R6 fetch_ready", 32'(fetch_ready), 32'(m_efr));
            chk(coef_ready == m_ecr, "R5 coef_ready", 32'(coef_ready), 32'(m_ecr));
            chk(pm_req == (m_gf || m_gc), "R10 pm_req", 32'(pm_req), 32'(m_gf || m_gc));
            if (m_gf || m_gc)
                chk(pm_addr == (m_gf ? fetch_addr : coef_addr), "R4 pm_addr",
                    32'(pm_addr), 32'(m_gf ? fetch_addr : coef_addr));
            chk(fetch_valid == e_fv, "R2 fetch_valid", 32'(fetch_valid), 32'(e_fv));
            if (e_fv) chk(fetch_instr == e_fi, "R2 fetch_instr", fetch_instr, e_fi);
            chk(coef_valid == e_cv, "R3 coef_valid", 32'(coef_valid), 32'(e_cv));
            if (e_cv) chk(coef_data == e_cd, "R3 coef_data", coef_data, e_cd);

            if (m_gf) ireads++;

            if (mpend && !flush) begin      // R7 round-robin fill
                mv[mptr] = 1; mt[mptr] = mpaddr; mptr = (mptr + 1) % 32;
            end
            if (flush) begin                // R8
                for (int i = 0; i < 32; i++) mv[i] = 0;
                mptr = 0;
            end
            mpend  = m_gf;
            mpaddr = fetch_addr;
            mwait  = coef_req && !m_ecr;
            e_fv = fetch_req && m_efr; e_fi = memf(fetch_addr);
            e_cv = m_gc;               e_cd = memf(coef_addr);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic issue(input bit fr, input logic [15:0] fa, input bit cr, input logic [15:0] ca,
                         output int cycles);
        bit af, ac;
        fetch_req = fr; fetch_addr = fa; coef_req = cr; coef_addr = ca;
        cycles = 0;
        forever begin
            @(negedge clk);
            af = fetch_req && fetch_ready;
            ac = coef_req && coef_ready;
            @(posedge clk); #1;
            cycles++;
            if (af) fetch_req = 0;
            if (ac) coef_req = 0;
            if (!fetch_req && !coef_req) break;
        end
    endtask

    task automatic pulse_flush();
        flush = 1; @(posedge clk); #1; flush = 0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_up();
    end

    initial begin
        int cyc, tot;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(!fetch_valid && !coef_valid && !pm_req, "R1 reset state",
            {fetch_valid, coef_valid, pm_req}, 32'd0);
        @(posedge clk); #1;

        // Loop of 8 with a coefficient each step: first pass collides
        tot = 0; ireads = 0;
        for (int i = 0; i < 8; i++) begin
            issue(1, 16'h0040 + 16'(i), 1, 16'h0800 + 16'(i), cyc); tot += cyc;
        end
        chk(tot == 16, "R5 first pass cycles", tot, 16);
        chk(ireads == 8, "R1 cold store misses", ireads, 8);
        tot = 0; ireads = 0;
        for (int i = 0; i < 8; i++) begin
            issue(1, 16'h0040 + 16'(i), 1, 16'h0810 + 16'(i), cyc); tot += cyc;
        end
        chk(tot == 8, "R3 second pass cycles", tot, 8);
        chk(ireads == 0, "R2 second pass port reads", ireads, 0);

        // Back-to-back fetch of same missing address
        ireads = 0;
        issue(1, 16'h0090, 0, 0, cyc);
        issue(1, 16'h0090, 0, 0, cyc);
        chk(ireads == 1, "R9 in-flight forward", ireads, 1);

        // Flush then refetch
        pulse_flush();
        ireads = 0;
        issue(1, 16'h0040, 0, 0, cyc);
        chk(ireads == 1, "R8 flush invalidates", ireads, 1);
        // Fill landing in the flush cycle is dropped
        fetch_req = 1; fetch_addr = 16'h0050;
        @(posedge clk); #1; fetch_req = 0; flush = 1;
        @(posedge clk); #1; flush = 0;
        ireads = 0;
        issue(1, 16'h0050, 0, 0, cyc);
        chk(ireads == 1, "R8 same-cycle fill dropped", ireads, 1);

        // Capacity and round-robin eviction
        pulse_flush();
        for (int i = 0; i < 32; i++) issue(1, 16'h0100 + 16'(i), 0, 0, cyc);
        ireads = 0;
        for (int i = 0; i < 32; i++) issue(1, 16'h0100 + 16'(i), 0, 0, cyc);
        chk(ireads == 0, "R7 32 entries held", ireads, 0);
        issue(1, 16'h0120, 0, 0, cyc);
        ireads = 0;
        issue(1, 16'h0101, 0, 0, cyc);
        chk(ireads == 0, "R7 second fill survives", ireads, 0);
        issue(1, 16'h0100, 0, 0, cyc);
        chk(ireads == 1, "R7 oldest fill evicted", ireads, 1);

        // Stalled coefficient beats a new miss
        fetch_req = 1; fetch_addr = 16'h0200; coef_req = 1; coef_addr = 16'h0900;
        @(negedge clk);
        chk(fetch_ready && !coef_ready, "R5 miss wins collision", {fetch_ready, coef_ready}, 32'b10);
        @(posedge clk); #1; fetch_addr = 16'h0201;
        @(negedge clk);
        chk(!fetch_ready && coef_ready, "R6 stalled coef first", {fetch_ready, coef_ready}, 32'b01);
        @(posedge clk); #1; coef_req = 0;
        @(negedge clk);
        chk(fetch_ready && pm_req && pm_addr == 16'h0201, "R6 held miss served",
            {fetch_ready, pm_req, pm_addr}, {1'b1, 1'b1, 16'h0201});
        @(posedge clk); #1; fetch_req = 0;

        // Pipelined random traffic
        begin
            int pc = 0;
            bit af, ac;
            repeat (3000) begin
                @(negedge clk);
                af = fetch_req && fetch_ready;
                ac = coef_req && coef_ready;
                @(posedge clk); #1;
                if (!fetch_req || af) begin
                    fetch_req = ($urandom_range(0, 3) != 0);
                    pc = ($urandom_range(0, 15) == 0) ? int'($urandom_range(0, 47)) : (pc + 1) % 48;
                    fetch_addr = 16'h0300 + 16'(pc);
                end
                if (!coef_req || ac) begin
                    coef_req  = $urandom_range(0, 1) != 0;
                    coef_addr = 16'h0800 + 16'($urandom_range(0, 255));
                end
                flush = ($urandom_range(0, 63) == 0);
            end
            @(posedge clk); #1;
            fetch_req = 0; coef_req = 0; flush = 0;
            repeat (3) @(posedge clk);
        end
        finish_up();
    end

endmodule